// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tracking

This block is the receive-side character queue of a serial line controller. Each character pushed by the receiver carries three error marks: break, framing and parity. The marks are stored alongside the byte. The queue is show-ahead: the byte at the head and that byte's three error marks are visible at the outputs without a read. A read strobe from the host removes the head, and the outputs then show the next character's byte and marks.

A tally of stored characters that carry any error drives a summary error output. That output stays high while at least one marked character remains anywhere in the queue, even when the head itself is clean. It falls only when the last marked character has been read out.

A push into a full queue loses the incoming character and sets a sticky overrun flag. That flag holds until the host reads line status. The queue depth and the data width are parameters.

Top module: `rx_err_fifo`

## Requirements
- R1: `data_ready` is 1 exactly when the queue holds at least one character, and `level` equals the number of stored characters, from 0 to DEPTH. Both are 0 after reset.
- R2: Characters leave in the order they were accepted. `rd_data` shows the head byte with no read needed, and a pulse of `rd_en` on a non-empty queue removes the head at the next clock edge.
- R3: `head_brk`, `head_frm` and `head_par` show the break, framing and parity marks of the current head character. After a read they show the marks of the new head.
- R4: While the queue is empty, `rd_data`, `head_brk`, `head_frm` and `head_par` are all 0.
- R5: `any_err` is 1 in every cycle in which at least one stored character has any of its three marks set. This includes characters that are not at the head.
- R6: `any_err` falls only on the clock edge that removes the last stored character that carries a mark. Reading clean characters never clears it.
- R7: When `wr_en` and `rd_en` are asserted together on a queue that is neither empty nor full, `level` is unchanged. The error tally adds the incoming marks and removes the outgoing ones in the same edge.
- R8: When `wr_en` is asserted while `level` equals DEPTH, the character is discarded, `overrun` becomes 1 at the next edge, and the stored contents are unchanged. This holds even if `rd_en` is asserted in the same cycle.
- R9: `overrun` stays 1 until a cycle with `lsr_rd` asserted, and clears at that edge. If a discarded push falls in the same cycle as `lsr_rd`, `overrun` stays 1.
- R10: `rd_en` on an empty queue has no effect: `level` stays 0 and no later character is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_data | input | DATA_W | Received byte |
| wr_brk | input | 1 | Break mark of the pushed character |
| wr_frm | input | 1 | Framing error mark of the pushed character |
| wr_par | input | 1 | Parity error mark of the pushed character |
| rd_en | input | 1 | Host read strobe, pops the head |
| lsr_rd | input | 1 | Host line-status read, clears overrun |
| rd_data | output | DATA_W | Head byte (0 when empty) |
| data_ready | output | 1 | Queue is not empty |
| head_brk | output | 1 | Break mark of the head character |
| head_frm | output | 1 | Framing mark of the head character |
| head_par | output | 1 | Parity mark of the head character |
| any_err | output | 1 | Some stored character carries a mark |
| overrun | output | 1 | Sticky lost-character flag |
| level | output | $clog2(DEPTH+1) | Stored character count |

## Verification
A push and a pop can land on the same edge. In that cycle both the occupancy count and the error tally must account for one character entering and one leaving. Depending on the marks, the tally then nets to +1, -1 or 0.

The bench provokes this by holding the queue at every level from empty to full and issuing simultaneous push and pop with each combination of incoming and outgoing marks. It also covers the full case, where the push is dropped while the pop still proceeds.

Each cycle is judged against a queue model kept in the bench. The model pops first when the queue is not empty and pushes only when the pre-edge count was below the depth. `level`, the head outputs and `any_err` are compared right after the edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rxq_marks_t;

   localparam int MARK_W = $bits(rxq_marks_t);
endpackage

// File: rtl/rxq_ptrs.sv
module rxq_ptrs #(
   parameter int DEPTH = 64,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PW-1:0]    wr_ptr,
   output logic [PW-1:0]    rd_ptr,
   output logic [CNT_W-1:0] level
);
   localparam bit POW2 = (DEPTH == (1 << PW));

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
            end else begin
               if (push) wr_ptr <= wr_ptr + 1'b1;
               if (pop)  rd_ptr <= rd_ptr + 1'b1;
            end
         end
      end else begin : g_wrap_cmp
         localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
            end else begin
               if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
               if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  rxq_marks_t        wmarks,
   input  logic [PW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output rxq_marks_t        rmarks
);
   logic [DATA_W-1:0] data_mem [DEPTH];
   rxq_marks_t        mark_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         data_mem[waddr] <= wdata;
         mark_mem[waddr] <= wmarks;
      end
   end

   assign rdata  = data_mem[raddr];
   assign rmarks = mark_mem[raddr];
endmodule

// File: rtl/rxq_err_tally.sv
module rxq_err_tally #(
   parameter int DEPTH = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic add_bad,
   input  logic drop_bad,
   output logic any_bad
);
   logic [CNT_W-1:0] bad_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bad_cnt <= '0;
      end else begin
         case ({add_bad, drop_bad})
            2'b10:   bad_cnt <= bad_cnt + 1'b1;
            2'b01:   bad_cnt <= bad_cnt - 1'b1;
            default: bad_cnt <= bad_cnt;
         endcase
      end
   end

   assign any_bad = (bad_cnt != '0);
endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic lost,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)    flag <= 1'b0;
      else if (lost) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_brk,
   input  logic              wr_frm,
   input  logic              wr_par,
   input  logic              rd_en,
   input  logic              lsr_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              data_ready,
   output logic              head_brk,
   output logic              head_frm,
   output logic              head_par,
   output logic              any_err,
   output logic              overrun,
   output logic [CNT_W-1:0]  level
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_err_fifo: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_err_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic              full, empty, push, pop;
   logic [PW-1:0]     wr_ptr, rd_ptr;
   logic [DATA_W-1:0] mem_data;
   rxq_marks_t        in_marks, mem_marks, head_marks;

   assign full     = (level == CNT_W'(DEPTH));
   assign empty    = (level == '0);
   assign push     = wr_en & ~full;
   assign pop      = rd_en & ~empty;
   assign in_marks = '{brk: wr_brk, frm: wr_frm, par: wr_par};

   rxq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .level  (level)
   );

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .we     (push),
      .waddr  (wr_ptr),
      .wdata  (wr_data),
      .wmarks (in_marks),
      .raddr  (rd_ptr),
      .rdata  (mem_data),
      .rmarks (mem_marks)
   );

   assign head_marks = empty ? '0 : mem_marks;
   assign rd_data    = empty ? '0 : mem_data;
   assign head_brk   = head_marks.brk;
   assign head_frm   = head_marks.frm;
   assign head_par   = head_marks.par;
   assign data_ready = ~empty;

   rxq_err_tally #(.DEPTH(DEPTH)) u_tally (
      .clk      (clk),
      .rst_n    (rst_n),
      .add_bad  (push & (|in_marks)),
      .drop_bad (pop & (|head_marks)),
      .any_bad  (any_err)
   );

   rxq_ovr_flag u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .lost  (wr_en & full),
      .clr   (lsr_rd),
      .flag  (overrun)
   );
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              wr_brk,
   input logic              wr_frm,
   input logic              wr_par,
   input logic              rd_en,
   input logic              lsr_rd,
   input logic [DATA_W-1:0] rd_data,
   input logic              data_ready,
   input logic              head_brk,
   input logic              head_frm,
   input logic              head_par,
   input logic              any_err,
   input logic              overrun,
   input logic [CNT_W-1:0]  level
);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   // R1
   ready_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready == (level != '0));

   // R4
   empty_head_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_ready |-> (!head_brk && !head_frm && !head_par && rd_data == '0));

   // R5
   marked_push_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && level != FULL_LVL && (wr_brk || wr_frm || wr_par)) |=> any_err);

   // R6
   err_holds_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_err && !rd_en) |=> any_err);

   // R7
   push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && level != '0 && level != FULL_LVL) |=> $stable(level));

   // R8
   full_push_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && level == FULL_LVL) |=> overrun);

   // R9
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !lsr_rd) |=> overrun);

   // R10
   empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && level == '0) |=> level == '0);
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_err_fifo_tb.sv
`timescale 1ns/1ps
module rx_err_fifo_tb;
   localparam int DW    = 8;
   localparam int DEP   = 8;
   localparam int CW    = $clog2(DEP + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en, wr_brk, wr_frm, wr_par, rd_en, lsr_rd;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   logic          data_ready, head_brk, head_frm, head_par, any_err, overrun;
   logic [CW-1:0] level;

   int errors = 0;
   int checks = 0;
   bit done   = 0;
   string ctx = "";

   logic [DW+2:0] q [$];
   bit            m_ovr;

   always #4 clk = ~clk;

   rx_err_fifo #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en),
      .lsr_rd(lsr_rd), .rd_data(rd_data), .data_ready(data_ready),
      .head_brk(head_brk), .head_frm(head_frm), .head_par(head_par),
      .any_err(any_err), .overrun(overrun), .level(level)
   );

   task automatic cmp(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, ctx, act, exp);
      end
   endtask

   function automatic bit model_err();
      foreach (q[i]) if (q[i][DW+2:DW] != 3'b000) return 1'b1;
      return 1'b0;
   endfunction

   task automatic verify();
      logic [2:0]    em;
      logic [DW-1:0] ed;
      bit            ee;
      em = (q.size() > 0) ? q[0][DW+2:DW] : 3'b000;
      ed = (q.size() > 0) ? q[0][DW-1:0]  : '0;
      ee = model_err();
      cmp("R1 level", int'(level), q.size());
      cmp("R1 data_ready", int'(data_ready), int'(q.size() > 0));
      if (q.size() > 0) begin
         cmp("R2 rd_data", int'(rd_data), int'(ed));
         cmp("R3 head marks", int'({head_brk, head_frm, head_par}), int'(em));
      end else begin
         cmp("R4 rd_data", int'(rd_data), 0);
         cmp("R4 head marks", int'({head_brk, head_frm, head_par}), 0);
      end
      if (ee) cmp("R5 any_err", int'(any_err), 1);
      else    cmp("R6 any_err", int'(any_err), 0);
      cmp("R9 overrun", int'(overrun), int'(m_ovr));
   endtask

   task automatic step(bit w, logic [DW-1:0] d, logic [2:0] mk, bit r, bit l);
      bit full_pre;
      @(negedge clk);
      wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = mk; rd_en = r; lsr_rd = l;
      @(posedge clk);
      full_pre = (q.size() == DEP);
      if (r && q.size() > 0) void'(q.pop_front());
      if (w && !full_pre) q.push_back({mk, d});
      if (l) m_ovr = 0;
      if (w && full_pre) m_ovr = 1;
      #1;
      verify();
   endtask

   task automatic idle();
      step(0, '0, 3'b000, 0, 0);
   endtask

   task automatic drain();
      while (q.size() > 0) step(0, '0, 3'b000, 1, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      rst_n = 0; wr_en = 0; wr_data = '0; wr_brk = 0; wr_frm = 0; wr_par = 0;
      rd_en = 0; lsr_rd = 0; m_ovr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      ctx = "reset";
      #1 verify();

      // R3, R4: every mark combination, runs of one to three characters
      ctx = "mark sweep";
      for (int f = 0; f < 8; f++) begin
         for (int n = 1; n <= 3; n++) begin
            for (int k = 0; k < n; k++)
               step(1, 8'(f * 16 + n * 4 + k), 3'(f ^ k), 0, 0);
            drain();
         end
      end

      // R6: marked char behind clean ones; clean reads keep any_err
      ctx = "R6 persistence";
      step(1, 8'h11, 3'b000, 0, 0);
      step(1, 8'h22, 3'b100, 0, 0);
      step(1, 8'h33, 3'b000, 0, 0);
      step(1, 8'h44, 3'b001, 0, 0);
      drain();

      // R10: reads on empty queue, then a push must survive
      ctx = "R10 empty read";
      step(0, '0, 3'b000, 1, 0);
      step(0, '0, 3'b000, 1, 0);
      step(1, 8'h5A, 3'b010, 1, 0);
      step(0, '0, 3'b000, 0, 0);
      drain();

      // R8, R9: fill, overflow under every rd/lsr combination
      ctx = "R8 overflow";
      for (int c = 0; c < 4; c++) begin
         for (int k = 0; k < DEP; k++) step(1, 8'(k + 8 * c), 3'(k), 0, 0);
         step(1, 8'hEE, 3'b111, c[0], c[1]);
         idle();
         step(0, '0, 3'b000, 0, 1);
         drain();
      end
      ctx = "R9 hold";
      step(0, '0, 3'b000, 0, 0);
      step(0, '0, 3'b000, 0, 1);

      // R7: simultaneous push/pop at every level, every in/out mark pairing
      ctx = "R7 push+pop";
      for (int lv = 0; lv <= DEP; lv++) begin
         for (int mi = 0; mi < 4; mi++) begin
            for (int k = 0; k < lv; k++) step(1, 8'(k), (mi[1] ? 3'b010 : 3'b000), 0, 0);
            step(1, 8'(lv + 100), (mi[0] ? 3'b001 : 3'b000), 1, 0);
            step(1, 8'(lv + 120), 3'b000, 1, 0);
            drain();
            step(0, '0, 3'b000, 0, 1);
         end
      end

      // mixed traffic from an LFSR
      ctx = "mixed";
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0] | lf[1], lf[9:2], (lf[12:10] & {3{lf[13]}}), lf[14] & lf[3], lf[15] & lf[4]);
      end
      drain();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule